// File: doc/BRIEF.md
# Receive Character Queue with Idle Timeout

This block buffers characters coming out of an asynchronous serial receiver until the host collects them. Each slot holds one data byte and three error marks: parity, framing and break. An error mark stays hidden while its character waits behind others. It shows on the head outputs only once that character is the next one the host will read. The host reads one byte per read strobe, and the byte appears on `rd_data` one clock later.

The block raises two interrupts. The first is a level interrupt that is high while the fill reaches a threshold the host picks with a 2-bit code. The second is an idle interrupt. It fires when characters sit in the queue and, for four character times, no character has arrived and the host has not read. The block also drives data-ready, a sticky overrun bit and a summary error bit for the status register that sits outside it.

A break character is stored as a single zero byte. After it, the receive side stays locked until the deserializer reports that the line has gone back to mark and a valid start bit was seen. A clear pulse, or dropping the enable, empties the queue.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to 16 characters. `data_ready` is high, one clock after the causing edge, exactly when at least one character is held. After reset every output is 0.
- R2: `trig_sel` codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 characters. `trig_irq` is high while the number held is at or above the threshold, and it drops in the cycle after the fill falls below it.
- R3: `tmo_irq` rises after the fourth `char_tick` pulse that follows the last received character and the last host read, provided at least one character is held. It never rises while the queue is empty.
- R4: A received character, or a `host_rd` pulse, restarts the idle count and clears `tmo_irq`.
- R5: `head_par`, `head_frm` and `head_brk` show the marks of the oldest held character only, and show 0 when the queue is empty.
- R6: When a character completes while 16 are held and no read occurs in that cycle, `overrun` sets and the character is dropped. The held contents are unchanged. `overrun` clears on an `lsr_rd` pulse.
- R7: A character with `rx_brk` set is stored as byte 0x00 with its break mark set. Further characters are dropped until a `rx_rearm` pulse.
- R8: A `fifo_clr` pulse, or `fifo_en` at 0, empties the queue. While `fifo_en` is 0, arriving characters are not stored.
- R9: `fifo_err` sets when a character with any error mark is stored. An `lsr_rd` pulse clears it only if no held character carries an error mark.
- R10: A `host_rd` pulse while the queue is empty leaves `rd_data` at its last value, and the fill does not go below zero.
- R11: Characters are read back in arrival order. Each `host_rd` pulse puts the oldest byte on `rd_data` one clock later.
- R12: If a character completes in the same cycle that the host reads from a full queue, the character is stored and `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | One-cycle strobe: a received character is complete |
| rx_data | input | 8 | Received data byte |
| rx_par | input | 1 | Parity error mark of the character |
| rx_frm | input | 1 | Framing error mark of the character |
| rx_brk | input | 1 | Break mark of the character |
| rx_rearm | input | 1 | Pulse: the line is back at mark and a valid start bit was seen |
| host_rd | input | 1 | Pulse: the host reads one character |
| lsr_rd | input | 1 | Pulse: the host reads line status |
| fifo_en | input | 1 | Queue enable; at 0 the queue is held empty |
| fifo_clr | input | 1 | Pulse: empty the queue |
| trig_sel | input | 2 | Threshold select code |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Last byte read |
| head_par | output | 1 | Parity mark of the oldest character |
| head_frm | output | 1 | Framing mark of the oldest character |
| head_brk | output | 1 | Break mark of the oldest character |
| data_ready | output | 1 | At least one character held |
| overrun | output | 1 | Sticky overrun status |
| fifo_err | output | 1 | Summary error status |
| trig_irq | output | 1 | Threshold interrupt |
| tmo_irq | output | 1 | Idle timeout interrupt |

## Verification
Two events can land on the same edge: an arriving character on a full queue, and a host read. The bench fills all 16 slots. It then raises `rx_valid` and `host_rd` in one cycle and expects that `overrun` stays low. It also expects the oldest byte on `rd_data` and the new byte to come out last after the queue is drained. The same arrival without the read must instead set `overrun`, and all 16 original bytes must then read back unchanged.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxq_flags_t;

  // threshold code -> fill level at which the level interrupt rises
  function automatic int unsigned rxq_threshold(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  rxq_flags_t       wflags,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output rxq_flags_t       head_flags,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    count_nx,
  output logic             full,
  output logic             empty
);
  logic [DW-1:0] mem_q [DEPTH];
  rxq_flags_t    flg_q [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head_flags = empty ? '0 : flg_q[rptr];

  always_comb begin
    if (clr)
      count_nx = '0;
    else
      count_nx = count + CW'(push) - CW'(pop);
  end

  // data array: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (push) begin
      mem_q[wptr] <= wdata;
      flg_q[wptr] <= wflags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (pop)
      rdata <= mem_q[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count_nx;
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    !(push && full && !pop));
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty));
  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int LIMIT = 4,
  localparam int TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  input  logic held_nx,
  output logic expired
);
  logic [TW-1:0] cnt, cnt_nx;

  always_comb begin
    if (restart)
      cnt_nx = '0;
    else if (tick && cnt != TW'(LIMIT))
      cnt_nx = cnt + 1'b1;
    else
      cnt_nx = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      cnt     <= cnt_nx;
      expired <= held_nx && (cnt_nx == TW'(LIMIT));
    end
  end

  p_restart_clears_r4: assert property (@(posedge clk) disable iff (rst)
    restart |=> !expired);
  p_needs_data_r3: assert property (@(posedge clk) disable iff (rst)
    !held_nx |=> !expired);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int TMO_CHARS = 4,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par,
  input  logic          rx_frm,
  input  logic          rx_brk,
  input  logic          rx_rearm,
  input  logic          host_rd,
  input  logic          lsr_rd,
  input  logic          fifo_en,
  input  logic          fifo_clr,
  input  logic [1:0]    trig_sel,
  input  logic          char_tick,
  output logic [DW-1:0] rd_data,
  output logic          head_par,
  output logic          head_frm,
  output logic          head_brk,
  output logic          data_ready,
  output logic          overrun,
  output logic          fifo_err,
  output logic          trig_irq,
  output logic          tmo_irq
);
  logic          clr, brk_lock, full, empty, rx_take, push, pop;
  logic [CW-1:0] count, count_nx, err_cnt, err_nx;
  rxq_flags_t    in_flags, head_flags;
  logic [DW-1:0] in_data;
  logic          push_err, pop_err;

  assign clr      = fifo_clr || !fifo_en;
  assign rx_take  = rx_valid && fifo_en && !fifo_clr && !brk_lock;
  assign pop      = host_rd && !empty && !clr;
  assign push     = rx_take && (!full || pop);
  assign in_flags = '{brk: rx_brk, frm: rx_frm, par: rx_par};
  assign in_data  = rx_brk ? '0 : rx_data;
  assign push_err = push && (|in_flags);
  assign pop_err  = pop && (|head_flags);
  assign err_nx   = clr ? '0 : err_cnt + CW'(push_err) - CW'(pop_err);

  assign head_par = head_flags.par;
  assign head_frm = head_flags.frm;
  assign head_brk = head_flags.brk;

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .wdata(in_data),
    .wflags(in_flags), .pop(pop), .rdata(rd_data), .head_flags(head_flags),
    .count(count), .count_nx(count_nx), .full(full), .empty(empty)
  );

  rxq_idle_timer #(.LIMIT(TMO_CHARS)) u_idle (
    .clk(clk), .rst(rst), .restart(push || host_rd || clr),
    .tick(char_tick), .held_nx(count_nx != '0), .expired(tmo_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      trig_irq   <= 1'b0;
      overrun    <= 1'b0;
      fifo_err   <= 1'b0;
      brk_lock   <= 1'b0;
      err_cnt    <= '0;
    end else begin
      data_ready <= (count_nx != '0);
      trig_irq   <= (32'(count_nx) >= rxq_threshold(trig_sel));
      err_cnt    <= err_nx;
      if (rx_take && full && !pop)
        overrun <= 1'b1;
      else if (lsr_rd)
        overrun <= 1'b0;
      if (clr)
        fifo_err <= 1'b0;
      else if (push_err)
        fifo_err <= 1'b1;
      else if (lsr_rd && err_nx == '0)
        fifo_err <= 1'b0;
      if (clr)
        brk_lock <= 1'b0;
      else if (push && rx_brk)
        brk_lock <= 1'b1;
      else if (rx_rearm)
        brk_lock <= 1'b0;
    end
  end

  p_overrun_set_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_take && full && !host_rd) |=> overrun);
  p_full_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (full && !host_rd && !clr) |=> full);
  p_ready_tracks_r1: assert property (@(posedge clk) disable iff (rst)
    data_ready == !empty);
  p_empty_read_r10: assert property (@(posedge clk) disable iff (rst)
    (host_rd && empty) |=> $stable(rd_data));
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!data_ready && !trig_irq && !tmo_irq));
  p_head_empty_r5: assert property (@(posedge clk) disable iff (rst)
    empty |-> !(head_par || head_frm || head_brk));
endmodule

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 0, rx_par = 0, rx_frm = 0, rx_brk = 0, rx_rearm = 0;
  logic [7:0] rx_data = 0;
  logic       host_rd = 0, lsr_rd = 0, fifo_en = 1, fifo_clr = 0, char_tick = 0;
  logic [1:0] trig_sel = 0;
  logic [7:0] rd_data;
  logic       head_par, head_frm, head_brk, data_ready, overrun, fifo_err;
  logic       trig_irq, tmo_irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxq_top u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par(rx_par), .rx_frm(rx_frm), .rx_brk(rx_brk), .rx_rearm(rx_rearm),
    .host_rd(host_rd), .lsr_rd(lsr_rd), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
    .trig_sel(trig_sel), .char_tick(char_tick), .rd_data(rd_data),
    .head_par(head_par), .head_frm(head_frm), .head_brk(head_brk),
    .data_ready(data_ready), .overrun(overrun), .fifo_err(fifo_err),
    .trig_irq(trig_irq), .tmo_irq(tmo_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic p = 0, input logic f = 0,
                      input logic b = 0);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_par = p; rx_frm = f; rx_brk = b;
    @(negedge clk);
    rx_valid = 0; rx_par = 0; rx_frm = 0; rx_brk = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic pulse_lsr();
    @(negedge clk); lsr_rd = 1;
    @(negedge clk); lsr_rd = 0;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1;
    @(negedge clk); char_tick = 0;
  endtask

  task automatic clear_q();
    @(negedge clk); fifo_clr = 1;
    @(negedge clk); fifo_clr = 0;
  endtask

  task automatic pop_exp(input string req, input logic [7:0] exp);
    pulse_rd();
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 reset data_ready", data_ready, 0);
    chk("R1 reset irqs", {trig_irq, tmo_irq}, 0);
    chk("R1 reset status", {overrun, fifo_err}, 0);
    chk("R1 reset rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    push(8'hA1); chk("R1 ready after one", data_ready, 1);
    push(8'hB2); push(8'hC3);
    pop_exp("R11 order first", 8'hA1);
    pop_exp("R11 order second", 8'hB2);
    pop_exp("R11 order third", 8'hC3);
    chk("R1 ready after drain", data_ready, 0);
  endtask

  task automatic t_trigger();
    for (int s = 0; s < 4; s++) begin
      int thr;
      thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      trig_sel = 2'(s);
      for (int i = 0; i < thr - 1; i++) push(8'(i));
      chk($sformatf("R2 below threshold sel=%0d", s), trig_irq, 0);
      push(8'h77);
      chk($sformatf("R2 at threshold sel=%0d", s), trig_irq, 1);
      pulse_rd();
      chk($sformatf("R2 drop below sel=%0d", s), trig_irq, 0);
      clear_q();
    end
    trig_sel = 2'd3;
  endtask

  task automatic t_timeout();
    repeat (5) tick();
    chk("R3 no timeout while empty", tmo_irq, 0);
    push(8'h10); push(8'h11);
    repeat (3) tick();
    chk("R3 three ticks quiet", tmo_irq, 0);
    tick();
    chk("R3 fourth tick fires", tmo_irq, 1);
    pulse_rd();
    chk("R4 host read clears", tmo_irq, 0);
    repeat (2) tick();
    push(8'h12);
    repeat (3) tick();
    chk("R4 arrival restarts count", tmo_irq, 0);
    tick();
    chk("R3 fires after restart", tmo_irq, 1);
    push(8'h13);
    chk("R4 arrival clears", tmo_irq, 0);
    clear_q();
  endtask

  task automatic t_flags();
    push(8'h01); push(8'h02, 1, 0, 0); push(8'h03, 0, 1, 0);
    chk("R5 clean head", {head_brk, head_frm, head_par}, 0);
    pulse_rd();
    chk("R5 parity at head", {head_brk, head_frm, head_par}, 3'b001);
    pulse_rd();
    chk("R5 framing at head", {head_brk, head_frm, head_par}, 3'b010);
    pulse_rd();
    chk("R5 empty head", {head_brk, head_frm, head_par}, 0);
    pulse_lsr();
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    chk("R6 no overrun at full", overrun, 0);
    push(8'hEE);
    chk("R6 overrun set", overrun, 1);
    for (int i = 0; i < 16; i++) pop_exp("R6 contents kept", 8'(8'h40 + i));
    chk("R6 extra dropped", data_ready, 0);
    chk("R6 overrun sticky", overrun, 1);
    pulse_lsr();
    chk("R6 overrun cleared by lsr", overrun, 0);
  endtask

  task automatic t_same_cycle();
    for (int i = 0; i < 16; i++) push(8'(8'h60 + i));
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h9C; host_rd = 1;
    @(negedge clk);
    rx_valid = 0; host_rd = 0;
    chk("R12 no overrun on read+arrive", overrun, 0);
    chk("R12 oldest read out", rd_data, 8'h60);
    for (int i = 1; i < 16; i++) pop_exp("R12 drain", 8'(8'h60 + i));
    pop_exp("R12 new byte last", 8'h9C);
    chk("R12 empty after drain", data_ready, 0);
  endtask

  task automatic t_break();
    push(8'h55, 0, 0, 1);
    chk("R7 break head flag", head_brk, 1);
    push(8'h11);
    @(negedge clk); rx_rearm = 1;
    @(negedge clk); rx_rearm = 0;
    push(8'h22);
    pop_exp("R7 break stored as zero", 8'h00);
    pop_exp("R7 load after rearm", 8'h22);
    chk("R7 blocked byte absent", data_ready, 0);
    pulse_lsr();
  endtask

  task automatic t_clear();
    push(1); push(2); push(3);
    clear_q();
    chk("R8 clear pulse empties", data_ready, 0);
    @(negedge clk); fifo_en = 0;
    push(8'h44);
    chk("R8 disabled drops", data_ready, 0);
    @(negedge clk); fifo_en = 1;
    @(negedge clk);
    chk("R8 still empty on enable", data_ready, 0);
    push(8'h45);
    pop_exp("R8 works after enable", 8'h45);
  endtask

  task automatic t_err();
    push(8'h70, 0, 1, 0); push(8'h71);
    chk("R9 summary set", fifo_err, 1);
    pulse_lsr();
    chk("R9 held error keeps summary", fifo_err, 1);
    pulse_rd();
    pulse_lsr();
    chk("R9 summary cleared", fifo_err, 0);
    pulse_rd();
  endtask

  task automatic t_empty_read();
    push(8'h5A);
    pop_exp("R10 normal read", 8'h5A);
    pulse_rd();
    chk("R10 empty read keeps value", rd_data, 8'h5A);
    chk("R10 still empty", data_ready, 0);
    push(8'h6B);
    chk("R10 one held, no underflow", data_ready, 1);
    pop_exp("R10 next read", 8'h6B);
    chk("R10 empty again", data_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_order();
    t_trigger();
    t_timeout();
    t_flags();
    t_overrun();
    t_same_cycle();
    t_break();
    t_clear();
    t_err();
    t_empty_read();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule